// File: doc/BRIEF.md
# Edge-Capture Timer Channel

This block is one capture channel of a general-purpose timer. A free-running up-counter runs continuously. An external input is brought into the clock domain through a short synchronizer chain. When the chosen edge of that input is seen, the current counter value is copied into a capture register. At the same moment a pending flag is set, and an optional one-cycle trigger pulse is issued towards other timers.

Software controls the channel through a small register port that has a two-bit address, separate read and write strobes, and a combinational read path. The interrupt request is a level: it follows the pending flag masked by its enable bit. Reading the captured value clears the pending flag. A capture that lands while the flag is still pending overwrites the register and raises a sticky overcapture flag. Each flag is cleared by writing 0 to its bit in the status register.

Top module: `icap_channel`

## Requirements
- R1: After reset the capture register, counter, pending flag, overcapture flag, control bits, `irq` and `trig_out` are all 0.
- R2: The register map is as follows. Address 0 is control: bit0 enables the channel, bit1 enables the interrupt, bit2 selects the edge, and bits[6:4] hold the trigger source select. Address 1 is status: bit0 is pending and bit1 is overcapture. Address 2 is the captured value and is read-only. Address 3 is the live counter and is read-only. Read data is combinational from the address while the read strobe is high.
- R3: With edge select 0 and the channel enabled, a 0-to-1 change of `cap_in` latches the counter. The value stored is the counter value in the cycle before the third rising clock edge after the input changes, and it is visible from that third edge on.
- R4: With edge select 1, only a 1-to-0 change of `cap_in` captures. The opposite edge changes neither the register nor the flags.
- R5: Every capture sets the pending flag.
- R6: `irq` is high in every cycle in which both the pending flag and the interrupt-enable bit are 1, and it is low otherwise. It stays high and does not fall back to 0 after a cycle.
- R7: A read strobe at address 2 clears the pending flag. If a capture happens in the same cycle, the read returns the previous value and the pending flag stays 1.
- R8: A capture while pending is 1 overwrites the captured value and sets overcapture. Overcapture is cleared only by writing 0 to status bit1. Writing 0 to status bit0 clears pending. Writing 1 to either bit leaves that flag unchanged.
- R9: When the trigger source select equals 3'b011, `trig_out` is high for exactly one cycle for every capture, overcaptures included. That cycle is the first cycle in which the new captured value is visible. For other select values `trig_out` stays 0.
- R10: While the channel-enable bit is 0, input edges cause no capture, no flag change and no trigger pulse.
- R11: The counter increments every cycle out of reset and wraps from 16'hFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_in | input | 1 | Asynchronous capture input |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read side effects) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| irq | output | 1 | Level interrupt request |
| trig_out | output | 1 | One-cycle capture trigger |

## Verification
A capture and a read of the captured value can land on the same clock edge. When they do, the capture must win. The bench times a read strobe so that it is high exactly at the edge on which a synchronized input edge is latched. It then checks three things: that the returned data is the previous captured value, that the pending flag is still set afterwards, and that a later read shows the new value. A seeded random sequence also interleaves edges, flag writes and reads, so overcaptures against pending and against cleared flags both occur.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic [1:0] {
        A_CTRL  = 2'd0,
        A_STAT  = 2'd1,
        A_CAP   = 2'd2,
        A_COUNT = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [2:0] tsel;
        logic       pol;
        logic       ie;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic ovr;
        logic pend;
    } flags_t;

    localparam logic [2:0] TSEL_ON_CAPTURE = 3'b011;

    function automatic ctrl_t ctrl_from_word(input logic [6:0] w);
        ctrl_t c;
        c.en   = w[0];
        c.ie   = w[1];
        c.pol  = w[2];
        c.tsel = w[6:4];
        return c;
    endfunction

    function automatic logic [6:0] ctrl_to_word(input ctrl_t c);
        return {c.tsel, 1'b0, c.pol, c.ie, c.en};
    endfunction

endpackage

// File: rtl/icap_sync_edge.sv
module icap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic fall_sel,
    output logic edge_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain[LAST];
    end

    always_comb begin
        if (fall_sel) edge_o = prev_q & ~chain[LAST];
        else          edge_o = chain[LAST] & ~prev_q;
    end
endmodule

// File: rtl/icap_counter.sv
module icap_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
    end
endmodule

// File: rtl/icap_regs.sv
module icap_regs
    import icap_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   bus_addr,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         edge_seen,
    input  logic [W-1:0] count,
    output ctrl_t        ctrl_q,
    output flags_t       flags_q,
    output logic [W-1:0] cap_q,
    output logic         cap_evt,
    output logic         irq,
    output logic         trig_out
);
    reg_addr_e addr;
    logic      wr_ctrl, wr_stat, rd_cap;
    logic      trig_q;
    logic      unused_wbits;

    assign addr    = reg_addr_e'(bus_addr);
    assign wr_ctrl = bus_wr && (addr == A_CTRL);
    assign wr_stat = bus_wr && (addr == A_STAT);
    assign rd_cap  = bus_rd && (addr == A_CAP);
    assign cap_evt = edge_seen && ctrl_q.en;

    assign unused_wbits = ^{bus_wdata[W-1:7], bus_wdata[3]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            flags_q <= '0;
            cap_q   <= '0;
            trig_q  <= 1'b0;
        end else begin
            trig_q <= cap_evt && (ctrl_q.tsel == TSEL_ON_CAPTURE);
            if (cap_evt) cap_q <= count;
            if (wr_ctrl) ctrl_q <= ctrl_from_word(bus_wdata[6:0]);
            if (cap_evt)
                flags_q.pend <= 1'b1;
            else if (rd_cap || (wr_stat && !bus_wdata[0]))
                flags_q.pend <= 1'b0;
            if (cap_evt && flags_q.pend)
                flags_q.ovr <= 1'b1;
            else if (wr_stat && !bus_wdata[1])
                flags_q.ovr <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (addr)
                A_CTRL:  bus_rdata = W'(ctrl_to_word(ctrl_q));
                A_STAT:  bus_rdata = W'(flags_q);
                A_CAP:   bus_rdata = cap_q;
                A_COUNT: bus_rdata = count;
            endcase
        end
    end

    assign irq      = flags_q.pend & ctrl_q.ie;
    assign trig_out = trig_q;
endmodule

// File: rtl/icap_channel.sv
module icap_channel
    import icap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_in,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq,
    output logic             trig_out
);
    ctrl_t            ctrl_q;
    flags_t           flags_q;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cap_q;
    logic             edge_seen;
    logic             cap_evt;

    icap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .din      (cap_in),
        .fall_sel (ctrl_q.pol),
        .edge_o   (edge_seen)
    );

    icap_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .count (count)
    );

    icap_regs #(.W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .edge_seen (edge_seen),
        .count     (count),
        .ctrl_q    (ctrl_q),
        .flags_q   (flags_q),
        .cap_q     (cap_q),
        .cap_evt   (cap_evt),
        .irq       (irq),
        .trig_out  (trig_out)
    );
endmodule

// File: rtl/icap_checker.sv
module icap_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   bus_addr,
    input logic         bus_rd,
    input logic         bus_wr,
    input logic [W-1:0] bus_wdata,
    input logic         irq,
    input logic         trig_out,
    input logic         pend,
    input logic         ovr,
    input logic         ie,
    input logic         en,
    input logic         cap_evt,
    input logic [W-1:0] cap_val
);
    AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (pend && ie) |-> irq); // R6
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> pend); // R6
    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        trig_out |=> !trig_out); // R9
    AST_TRIG_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        trig_out |-> pend); // R9
    AST_CAPTURE_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> pend); // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd2 && !cap_evt) |=> !pend); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovr && !(bus_wr && bus_addr == 2'd1 && !bus_wdata[1])) |=> ovr); // R8
    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> $past(pend)); // R8
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cap_val)); // R10
endmodule

bind icap_channel icap_checker #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .trig_out  (trig_out),
    .pend      (flags_q.pend),
    .ovr       (flags_q.ovr),
    .ie        (ctrl_q.ie),
    .en        (ctrl_q.en),
    .cap_evt   (cap_evt),
    .cap_val   (cap_q)
);

// File: tb/sim_icap_channel.sv
`timescale 1ns/1ps
module sim_icap_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_in = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, trig_out;

    int total = 0;
    int bad = 0;

    logic [15:0] mcount;
    logic        m_en, m_ie, m_pol, m_pend, m_ovr;
    logic [2:0]  m_sel;
    logic [15:0] m_cap;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) mcount <= '0;
        else     mcount <= mcount + 16'd1;
    end

    icap_channel u0 (
        .clk(clk), .rst(rst), .cap_in(cap_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .trig_out(trig_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        if (a == 2'd2) m_pend = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 2'd0) begin
            m_en = d[0]; m_ie = d[1]; m_pol = d[2]; m_sel = d[6:4];
        end else if (a == 2'd1) begin
            if (!d[0]) m_pend = 1'b0;
            if (!d[1]) m_ovr = 1'b0;
        end
    endtask

    function automatic logic is_capture(input logic oldv, input logic newv);
        if (!m_en) return 1'b0;
        return m_pol ? (oldv && !newv) : (!oldv && newv);
    endfunction

    // Drive a new input level; with_read places a capture read on the latch edge
    task automatic drive_edge(input logic lvl, input logic with_read, input string req);
        logic        evt;
        logic [15:0] expv, got;
        @(negedge clk);
        evt = is_capture(cap_in, lvl);
        cap_in = lvl;
        @(negedge clk);
        @(negedge clk);
        expv = mcount;
        if (with_read) begin
            bus_addr = 2'd2; bus_rd = 1'b1;
            #1 got = bus_rdata;
            chk("R7 read colliding with capture returns old value", got, m_cap);
        end
        @(negedge clk);
        bus_rd = 1'b0;
        if (with_read && !evt) m_pend = 1'b0;
        chk({req, " R9 trigger pulse"}, trig_out, evt && (m_sel == 3'b011));
        if (evt) begin
            if (m_pend) m_ovr = 1'b1;
            m_pend = 1'b1;
            m_cap  = expv;
        end
        chk({req, " R6 irq level"}, irq, m_pend && m_ie);
        @(negedge clk);
        chk({req, " R9 trigger width"}, trig_out, 1'b0);
    endtask

    task automatic check_regs(input string req);
        logic [15:0] d;
        bus_read(2'd1, d);
        chk({req, " R5 R8 status flags"}, d[1:0], {m_ovr, m_pend});
        chk({req, " R6 irq"}, irq, m_pend && m_ie);
        bus_read(2'd2, d);
        chk({req, " R3 captured value"}, d, m_cap);
        chk({req, " R7 pending cleared by read"}, irq, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int op;
        m_en = 0; m_ie = 0; m_pol = 0; m_sel = 0; m_pend = 0; m_ovr = 0; m_cap = 0;
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 trig", trig_out, 0);
        bus_read(2'd0, d); chk("R1 R2 control", d, 0);
        bus_read(2'd1, d); chk("R1 R2 status", d, 0);
        bus_read(2'd2, d); chk("R1 R2 capture", d, 0);

        // R10 disabled channel ignores edges
        bus_write(2'd0, 16'h0032);
        drive_edge(1'b1, 1'b0, "R10 disabled rise");
        drive_edge(1'b0, 1'b0, "R10 disabled fall");
        check_regs("R10");

        // R3 rising edge capture with trigger
        bus_write(2'd0, 16'h0033);
        drive_edge(1'b1, 1'b0, "R3 rise");
        bus_read(2'd1, d); chk("R5 pending set", d[1:0], 2'b01);
        chk("R6 irq held", irq, 1'b1);
        repeat (5) @(negedge clk);
        chk("R6 irq still level", irq, 1'b1);
        // R8 overcapture and R4-style opposite edge ignored
        drive_edge(1'b0, 1'b0, "R3 fall ignored");
        drive_edge(1'b1, 1'b0, "R8 overcapture");
        check_regs("R8");
        bus_write(2'd1, 16'h0003);
        bus_read(2'd1, d); chk("R8 write 1 keeps overcapture", d[1:0], {m_ovr, m_pend});
        bus_write(2'd1, 16'h0001);
        bus_read(2'd1, d); chk("R8 write 0 clears overcapture", d[1:0], 2'b00);

        // R4 falling-edge select, other trigger select
        bus_write(2'd0, 16'h0027);
        drive_edge(1'b0, 1'b0, "R4 fall");
        drive_edge(1'b1, 1'b0, "R4 rise ignored");
        check_regs("R4");

        // R7 collision: read on the capture edge
        bus_write(2'd0, 16'h0037);
        drive_edge(1'b0, 1'b1, "R7 collide");
        bus_read(2'd1, d); chk("R7 pending survives collision", d[0], 1'b1);
        check_regs("R7");

        // random mix
        for (int i = 0; i < 400; i++) begin
            op = $urandom_range(0, 6);
            case (op)
                0, 1, 2: drive_edge(~cap_in, ($urandom_range(0, 7) == 0), "rand");
                3: begin bus_read(2'd2, d); end
                4: begin
                    bus_read(2'd1, d);
                    chk("R8 rand status", d[1:0], {m_ovr, m_pend});
                end
                5: bus_write(2'd1, 16'($urandom_range(0, 3)));
                default: bus_write(2'd0, {9'd0,
                            ($urandom_range(0, 1) == 0) ? 3'b011 : 3'($urandom_range(0, 7)),
                            1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                            1'($urandom_range(0, 3) != 0)});
            endcase
            chk("R6 rand irq", irq, m_pend && m_ie);
        end
        check_regs("rand");

        // R11 wrap of the counter
        repeat (70000) @(negedge clk);
        @(negedge clk);
        bus_addr = 2'd3; bus_rd = 1'b1;
        #1 chk("R11 counter after wrap", bus_rdata, mcount);
        @(negedge clk);
        bus_rd = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule